// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer Bank

This block holds three 16-bit interval timers behind one small register bus. Each timer has a count, a mode and a target register. A timer advances on a tick from its selected source. It either returns to zero when it passes its target or runs on and wraps at all-ones. It reports each target hit or overflow through sticky status bits in its mode register. It can also send a one-cycle interrupt pulse to an external interrupt controller, either for every event or only for the first event after the mode was programmed.

The three timers differ only in their alternative clock source. Timer 0 can count a pixel-rate tick strobe. Timer 1 can count a line-rate (horizontal sync) tick strobe. Timer 2 can count the system clock divided by eight, and it can also be frozen. When no alternative source is selected, a timer advances on every system clock.

The register bus uses plain strobes with no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. A read is accepted in any cycle. Its data appears on `bus_rdata` one cycle later, qualified by `bus_rvalid`. The tick inputs are single-cycle strobes in the system clock domain.

Top module: `tick_timer_bank`

## Requirements
- R1: With mode bit 3 set, a step taken while the count equals the target loads the count with 0 and raises no event. Otherwise a step adds one to the count.
- R2: A step from 0xFFFF to 0 is an overflow event. It sets mode bits 12 and 10, and it raises an interrupt pulse when mode bit 5 is set. With mode bit 3 clear, the counter wraps from 0xFFFF to 0.
- R3: A step that makes the count equal the target is a target event. It sets mode bits 11 and 10, and it raises an interrupt pulse when mode bit 4 is set. The pulse lasts one cycle, and a target event and an overflow event on the same step give a single pulse.
- R4: With mode bit 6 clear, only the first pulse after a mode write is sent, and later qualifying events raise no pulse.
- R5: With mode bit 6 set, every qualifying event sends a pulse.
- R6: An event whose interrupt enable is clear still sets its status bits but sends no pulse.
- R7: A mode read returns the stored value, then clears bits 11 and 12. Bit 10 is kept.
- R8: An event in the same cycle as a mode read is not lost. The read returns the old value, and the new status bits are seen by the next read.
- R9: A mode write stores bits 12..0, reads bits 15..13 as zero, loads the count with 0 and re-arms the one-shot latch.
- R10: A target write leaves the count unchanged.
- R11: Mode bit 8 makes timer 0 step on `dot_tick` and timer 1 step on `hsync_tick`. Mode bit 9 makes timer 2 step once every 8 system clocks. Otherwise a timer steps on every clock.
- R12: On timer 2, mode bit 0 holds the count, though a count write still loads it.
- R13: The registers sit at byte address 0x10*n + {0x0 count, 0x4 mode, 0x8 target} for timer n. Any other or unaligned address reads 0. Read data follows the read strobe by one cycle. After reset, all registers are 0 and no pulse is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| dot_tick | input | 1 | Pixel-rate tick strobe for timer 0 |
| hsync_tick | input | 1 | Line-rate tick strobe for timer 1 |
| irq_pulse | output | 3 | One-cycle interrupt pulse per timer |

## Verification
A mode-register read and a counting event can fall in the same cycle. The read clears the sticky bits while the event sets them. The bench provokes this by raising a tick strobe in the very cycle it issues a mode read, on a step that reaches the target. It judges the outcome by three reads in a row: the first returns the pre-event value, the second shows the fresh flags, and the third shows them cleared. A target hit and an overflow are also made to coincide, and the bench checks that this produces exactly one pulse.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DATA_W  = 16;
  localparam int NUM_TMR = 3;

  // mode bit positions
  localparam int MB_STOP      = 0;
  localparam int MB_TGT_RESET = 3;
  localparam int MB_IRQ_TGT   = 4;
  localparam int MB_IRQ_OVF   = 5;
  localparam int MB_REPEAT    = 6;
  localparam int MB_ALT_SRC   = 8;
  localparam int MB_DIV_SRC   = 9;
  localparam int MB_EVT       = 10;
  localparam int MB_HIT_TGT   = 11;
  localparam int MB_HIT_OVF   = 12;

  localparam logic [DATA_W-1:0] MODE_KEEP   = 16'h1FFF;
  localparam logic [DATA_W-1:0] STICKY_MASK = 16'h1800;

  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_MODE   = 2'd1,
    REG_TARGET = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/timer_prescale.sv
module timer_prescale #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                     phase_q <= phase_q + 1'b1;
  end

  assign strobe = (phase_q == LAST);

  // R11
  div_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe || (DIV == 1));
endmodule

// File: rtl/timer_unit.sv
module timer_unit
  import timer_pkg::*;
#(
  parameter int ALT_BIT  = MB_ALT_SRC,
  parameter bit HAS_STOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_wr,
  input  logic              mode_wr,
  input  logic              tgt_wr,
  input  logic              mode_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              alt_tick,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] tgt_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] cnt_q, mode_q, tgt_q;
  logic              fired_q, irq_q;

  logic              stopped, src_tick, step, at_tgt;
  logic              tgt_evt, ovf_evt, want_irq, fire;
  logic [DATA_W-1:0] cnt_nxt, flag_set, mode_kept;

  always_comb begin
    stopped   = HAS_STOP && mode_q[MB_STOP];
    src_tick  = mode_q[ALT_BIT] ? alt_tick : 1'b1;
    step      = src_tick && !stopped && !cnt_wr;
    at_tgt    = mode_q[MB_TGT_RESET] && (cnt_q == tgt_q);
    cnt_nxt   = at_tgt ? '0 : cnt_q + 1'b1;
    ovf_evt   = step && !at_tgt && (cnt_q == '1);
    tgt_evt   = step && !at_tgt && (cnt_nxt == tgt_q);
    want_irq  = (tgt_evt && mode_q[MB_IRQ_TGT]) || (ovf_evt && mode_q[MB_IRQ_OVF]);
    fire      = want_irq && (mode_q[MB_REPEAT] || !fired_q);
    flag_set  = '0;
    flag_set[MB_EVT]     = tgt_evt || ovf_evt;
    flag_set[MB_HIT_TGT] = tgt_evt;
    flag_set[MB_HIT_OVF] = ovf_evt;
    mode_kept = mode_rd ? (mode_q & ~STICKY_MASK) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      mode_q  <= '0;
      tgt_q   <= '0;
      fired_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (tgt_wr) tgt_q <= wdata;
      if (mode_wr) begin
        mode_q  <= wdata & MODE_KEEP;
        cnt_q   <= '0;
        fired_q <= 1'b0;
        irq_q   <= 1'b0;
      end else begin
        mode_q <= mode_kept | flag_set;
        if (cnt_wr)    cnt_q <= wdata;
        else if (step) cnt_q <= cnt_nxt;
        irq_q <= fire;
        if (fire) fired_q <= 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
  assign tgt_o  = tgt_q;
  assign irq_o  = irq_q;

  // R1
  tgt_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[MB_TGT_RESET] && src_tick && !stopped && !cnt_wr && !mode_wr
     && cnt_q == tgt_q) |=> (cnt_q == '0));

  // R4
  oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !mode_q[MB_REPEAT] && !mode_wr) |=> !irq_q);

  // R9
  modewr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (cnt_q == '0 && !fired_q && !irq_q));

  // R10
  tgtwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_wr && !cnt_wr && !mode_wr && (!src_tick || stopped)) |=> $stable(cnt_q));

  // R7
  rdclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd && !mode_wr && !tgt_evt && !ovf_evt) |=> (mode_q[MB_HIT_OVF:MB_HIT_TGT] == 2'b00));

  // R8
  keepflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_evt && !mode_wr) |=> mode_q[MB_HIT_TGT]);

  // R12
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_STOP && mode_q[MB_STOP] && !cnt_wr && !mode_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import timer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DIV    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              dot_tick,
  input  logic              hsync_tick,
  output logic [NUM_TMR-1:0] irq_pulse
);
  localparam int RSEL_LSB = 2;
  localparam int TSEL_LSB = 4;
  localparam int MAP_W    = 6;

  logic              div_tick;
  logic              addr_ok;
  logic [1:0]        tsel;
  reg_sel_e          rsel;
  logic [NUM_TMR-1:0] alt_ticks;
  logic [DATA_W-1:0] cnt_a  [NUM_TMR];
  logic [DATA_W-1:0] mode_a [NUM_TMR];
  logic [DATA_W-1:0] tgt_a  [NUM_TMR];
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              rvalid_q;

  timer_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .strobe(div_tick)
  );

  assign alt_ticks = {div_tick, hsync_tick, dot_tick};

  always_comb begin
    addr_ok = (bus_addr[RSEL_LSB-1:0] == '0) && ((bus_addr >> MAP_W) == '0);
    tsel    = bus_addr[TSEL_LSB+1:TSEL_LSB];
    rsel    = reg_sel_e'(bus_addr[RSEL_LSB+1:RSEL_LSB]);
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam int ALT  = (i == 2) ? MB_DIV_SRC : MB_ALT_SRC;
    localparam bit STOP = (i == 2);
    logic hit;
    assign hit = addr_ok && (tsel == 2'(i));

    timer_unit #(.ALT_BIT(ALT), .HAS_STOP(STOP)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_wr   (bus_wr && hit && rsel == REG_COUNT),
      .mode_wr  (bus_wr && hit && rsel == REG_MODE),
      .tgt_wr   (bus_wr && hit && rsel == REG_TARGET),
      .mode_rd  (bus_rd && hit && rsel == REG_MODE),
      .wdata    (bus_wdata),
      .alt_tick (alt_ticks[i]),
      .cnt_o    (cnt_a[i]),
      .mode_o   (mode_a[i]),
      .tgt_o    (tgt_a[i]),
      .irq_o    (irq_pulse[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_TMR; k++) begin
      if (addr_ok && tsel == 2'(k)) begin
        case (rsel)
          REG_COUNT:  rd_mux = cnt_a[k];
          REG_MODE:   rd_mux = mode_a[k];
          REG_TARGET: rd_mux = tgt_a[k];
          default:    rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R13
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R13
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !addr_ok) |=> (bus_rdata == '0));
endmodule

// File: tb/sim_tick_timer_bank.sv
module sim_tick_timer_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        dot_tick = 1'b0, hsync_tick = 1'b0;
  logic [2:0]  irq_pulse;

  int checks = 0, fails = 0;
  int irq_seen [3] = '{0, 0, 0};
  int base;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  tick_timer_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .dot_tick(dot_tick), .hsync_tick(hsync_tick),
    .irq_pulse(irq_pulse)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data, counts interrupt pulses
  always @(negedge clk) begin
    if (rst_n) begin
      for (int t = 0; t < 3; t++) if (irq_pulse[t]) irq_seen[t]++;
      if (bus_rvalid && sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [15:0] e, string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    sb_q.push_back('{e, tag});
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rd_with_tick(logic [15:0] e, string tag);
    @(negedge clk); bus_addr = 6'h04; bus_rd = 1'b1; dot_tick = 1'b1;
    sb_q.push_back('{e, tag});
    @(negedge clk); bus_rd = 1'b0; dot_tick = 1'b0;
  endtask

  task automatic read_now(logic [5:0] a, output int v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic tick(int which, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (which == 0) dot_tick = 1'b1; else hsync_tick = 1'b1;
      @(negedge clk);
      dot_tick = 1'b0; hsync_tick = 1'b0;
    end
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v1, v2;
    repeat (4) @(negedge clk);
    // R13 reset state
    check(bus_rvalid === 1'b0 && irq_pulse === 3'b000, "R13 reset outputs", {bus_rvalid, irq_pulse}, 0);
    rst_n = 1'b1;
    rd(6'h14, 16'h0000, "R13 reset mode t1");
    rd(6'h28, 16'h0000, "R13 reset target t2");
    drain();

    // R1 R3 R4 target reset, target irq, one-shot
    wr(6'h08, 16'd3);
    wr(6'h04, 16'h0118);
    base = irq_seen[0];
    tick(0, 3);
    rd(6'h00, 16'd3, "R3 count at target");
    drain();
    check(irq_seen[0] - base == 1, "R3 target pulse", irq_seen[0] - base, 1);
    tick(0, 1);
    rd(6'h00, 16'd0, "R1 reset to zero past target");
    tick(0, 3);
    rd(6'h00, 16'd3, "R1 count again");
    drain();
    check(irq_seen[0] - base == 1, "R4 one-shot blocks", irq_seen[0] - base, 1);
    // R7 read then clear
    rd(6'h04, 16'h0D18, "R7 flags set");
    rd(6'h04, 16'h0518, "R7 flags cleared bit10 kept");

    // R5 repeat
    wr(6'h08, 16'd2);
    wr(6'h04, 16'h0158);
    drain();
    base = irq_seen[0];
    tick(0, 2); tick(0, 1); tick(0, 2);
    drain();
    check(irq_seen[0] - base == 2, "R5 repeat pulses", irq_seen[0] - base, 2);

    // R6 event without enable
    wr(6'h04, 16'h0108);
    base = irq_seen[0];
    tick(0, 2);
    drain();
    check(irq_seen[0] - base == 0, "R6 no pulse", irq_seen[0] - base, 0);
    rd(6'h04, 16'h0D08, "R6 flags set without enable");
    rd(6'h04, 16'h0508, "R7 cleared");

    // R8 read and event in same cycle
    tick(0, 1); tick(0, 1);
    rd_with_tick(16'h0508, "R8 read returns old value");
    rd(6'h04, 16'h0D08, "R8 event kept");
    rd(6'h04, 16'h0508, "R8 cleared after");

    // R9 mode write zeroes count, re-arms latch
    wr(6'h04, 16'h0118);
    rd(6'h00, 16'd0, "R9 count zeroed");
    drain();
    base = irq_seen[0];
    tick(0, 2);
    drain();
    check(irq_seen[0] - base == 1, "R9 latch re-armed", irq_seen[0] - base, 1);

    // R10 target write keeps count
    tick(0, 1); tick(0, 1);
    wr(6'h08, 16'd9);
    rd(6'h00, 16'd1, "R10 count kept");
    rd(6'h08, 16'd9, "R10 target stored");
    tick(0, 1);
    rd(6'h00, 16'd2, "R10 counts on");

    // R9 high bits read zero
    wr(6'h04, 16'hE108);
    rd(6'h04, 16'h0108, "R9 bits 15..13 zero");

    // R2 overflow on timer 1 with hsync ticks (R11)
    wr(6'h18, 16'h8000);
    wr(6'h14, 16'h0120);
    wr(6'h10, 16'hFFFE);
    drain();
    base = irq_seen[1];
    tick(1, 2);
    rd(6'h10, 16'h0000, "R2 wrapped");
    drain();
    check(irq_seen[1] - base == 1, "R2 overflow pulse", irq_seen[1] - base, 1);
    rd(6'h14, 16'h1520, "R2 overflow flags");
    rd(6'h14, 16'h0520, "R7 overflow flag cleared");

    // R3 target and overflow together give one pulse
    wr(6'h18, 16'h0000);
    wr(6'h14, 16'h0130);
    wr(6'h10, 16'hFFFF);
    drain();
    base = irq_seen[1];
    tick(1, 1);
    drain();
    check(irq_seen[1] - base == 1, "R3 single pulse", irq_seen[1] - base, 1);
    rd(6'h14, 16'h1D30, "R3 both flags");

    // R12 timer 2 stop
    wr(6'h24, 16'h0001);
    wr(6'h20, 16'h0040);
    repeat (20) @(negedge clk);
    rd(6'h20, 16'h0040, "R12 held while stopped");
    drain();

    // R11 divided and full-rate sources on timer 2
    wr(6'h24, 16'h0200);
    read_now(6'h20, v1);
    repeat (62) @(negedge clk);
    read_now(6'h20, v2);
    check(((v2 - v1) & 16'hFFFF) == 8, "R11 divide by 8", (v2 - v1) & 16'hFFFF, 8);
    wr(6'h24, 16'h0000);
    read_now(6'h20, v1);
    repeat (62) @(negedge clk);
    read_now(6'h20, v2);
    check(((v2 - v1) & 16'hFFFF) == 64, "R11 system clock", (v2 - v1) & 16'hFFFF, 64);

    // R13 unmapped addresses
    rd(6'h30, 16'h0000, "R13 no timer 3");
    rd(6'h0C, 16'h0000, "R13 no register 3");
    rd(6'h02, 16'h0000, "R13 unaligned");
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule